// File: doc/BRIEF.md
# Flag Latch and Branch Condition Evaluator

This block holds the working copy of the processor's flag byte beside the ALU, together with the two architectural copies of the flag register that sit in the register file. At one fixed T-state of each instruction it copies the active flag register into the working latch. The ALU then reads and modifies only the latch. Fetch overlaps execute, so the latch is copied back into the register file at a fixed T-state of the following instruction. That copy happens only if the instruction that just finished changed flags.

The block also decides whether a conditional jump, call or return is taken. It uses three condition bits from the opcode. Two of them pick a flag, and the third gives the value that flag must hold. A separate input marks relative conditional jumps, whose selection is narrowed to zero and carry. The sequencer supplies the T-state strobes, the instruction-boundary strobe and the exchange request for the active flag copy.

Top module: `flag_cond_unit`

## Requirements
- R1: After reset the working latch, both stored flag copies and the active-copy select are all zero.
- R2: A `t4_load` strobe copies the active stored flag byte into the working latch, visible one cycle later. `rf_flags` always shows the active stored copy.
- R3: When `alu_we` is high, each latch bit whose `alu_mask` bit is 1 takes the `alu_flags` bit, and every other bit holds. This never changes a stored copy.
- R4: `instr_end` with `instr_mod_flags` high marks a write-back as pending. The next `t3_wb` then copies the latch into the stored copy it was last loaded from, even if the active copy has been exchanged since.
- R5: `instr_end` with `instr_mod_flags` low leaves nothing pending, so a following `t3_wb` changes no stored copy.
- R6: A write-back clears the pending mark. A second `t3_wb` with no new `instr_end` writes nothing.
- R7: When a pending write-back and `t4_load` fall in the same cycle, the write-back happens first and the load receives the written value.
- R8: Flag positions are S=7, Z=6, P/V=2, C=0. `cc_field[2:1]` (opcode bits 5-4) selects Z for 00, C for 01, P/V for 10 and S for 11. `cond_taken` is 1 exactly when the selected latch bit equals `cc_field[0]` (opcode bit 3). It is combinational from the latch and the opcode bits.
- R9: With `cc_rel` high the select is forced to {0, `cc_field[1]`}, so only Z or C can be chosen. `cc_field[0]` is still the required value.
- R10: `af_swap` toggles the active stored copy. `rf_flags` follows on the next cycle, and the latch is untouched until the next `t4_load`.
- R11: `rf_we` writes `rf_wdata` into the active stored copy. If a write-back targets the same copy in that cycle, the write-back wins.
- R12: In a cycle with `t4_load`, an `alu_we` update is ignored and the latch takes the loaded value.
- R13: `carry` is latch bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t4_load | input | 1 | Load strobe: stored flags to latch |
| t3_wb | input | 1 | Write-back strobe: latch to stored flags if pending |
| instr_end | input | 1 | Instruction boundary strobe |
| instr_mod_flags | input | 1 | The finishing instruction changed flags |
| af_swap | input | 1 | Exchange the active stored flag copy |
| alu_we | input | 1 | ALU update enable |
| alu_flags | input | FW | ALU flag values |
| alu_mask | input | FW | Bits the ALU updates |
| rf_we | input | 1 | Direct write of the active stored copy |
| rf_wdata | input | FW | Data for the direct write |
| cc_field | input | 3 | Opcode bits 5-3 |
| cc_rel | input | 1 | Relative conditional jump |
| work_flags | output | FW | Working latch |
| rf_flags | output | FW | Active stored flag copy |
| carry | output | 1 | Carry bit of the latch |
| cond_taken | output | 1 | Condition satisfied |

## Verification
Every state change (load, ALU update, write-back, direct write and exchange) appears at the outputs one clock edge after the strobe. The bench drives inputs after an edge and reads the outputs shortly after the next edge. `cond_taken` is combinational, so it is checked in the same cycle. The bench holds the latch value fixed and sweeps all eight condition-field codes with and without the relative flag, reading the output after a short settle delay. Ordering cases such as a write-back meeting a load, or a write-back meeting a direct write, are driven in a single cycle and read one edge later.

// File: rtl/flag_cond_unit.sv
module flag_cond_unit #(
  parameter int FW     = 8,
  parameter int S_POS  = 7,
  parameter int Z_POS  = 6,
  parameter int PV_POS = 2,
  parameter int C_POS  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          t4_load,
  input  logic          t3_wb,
  input  logic          instr_end,
  input  logic          instr_mod_flags,
  input  logic          af_swap,
  input  logic          alu_we,
  input  logic [FW-1:0] alu_flags,
  input  logic [FW-1:0] alu_mask,
  input  logic          rf_we,
  input  logic [FW-1:0] rf_wdata,
  input  logic [2:0]    cc_field,
  input  logic          cc_rel,
  output logic [FW-1:0] work_flags,
  output logic [FW-1:0] rf_flags,
  output logic          carry,
  output logic          cond_taken
);

  logic [FW-1:0] bank [2];
  logic          active;
  logic          src_bank;
  logic          pend;
  logic [FW-1:0] latch_q;

  logic          wb_go;
  logic [FW-1:0] ld_val;
  logic [1:0]    sel;
  logic          sel_flag;

  assign wb_go  = t3_wb & pend;
  assign ld_val = (wb_go && src_bank == active) ? latch_q : bank[active];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)
        bank[b] <= '0;
      else if (wb_go && src_bank == 1'(b))
        bank[b] <= latch_q;
      else if (rf_we && active == 1'(b))
        bank[b] <= rf_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q  <= '0;
      src_bank <= 1'b0;
    end else if (t4_load) begin
      latch_q  <= ld_val;
      src_bank <= active;
    end else if (alu_we) begin
      latch_q  <= (latch_q & ~alu_mask) | (alu_flags & alu_mask);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      active <= 1'b0;
    end else begin
      if (instr_end)
        pend <= instr_mod_flags;
      else if (wb_go)
        pend <= 1'b0;
      if (af_swap)
        active <= ~active;
    end
  end

  assign sel = cc_rel ? {1'b0, cc_field[1]} : cc_field[2:1];

  always_comb begin
    case (sel)
      2'd0:    sel_flag = latch_q[Z_POS];
      2'd1:    sel_flag = latch_q[C_POS];
      2'd2:    sel_flag = latch_q[PV_POS];
      default: sel_flag = latch_q[S_POS];
    endcase
  end

  assign cond_taken = ~(sel_flag ^ cc_field[0]);
  assign work_flags = latch_q;
  assign rf_flags   = bank[active];
  assign carry      = latch_q[C_POS];

endmodule

module flag_cond_unit_chk #(
  parameter int FW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          t4_load,
  input logic          t3_wb,
  input logic          af_swap,
  input logic          alu_we,
  input logic [FW-1:0] alu_flags,
  input logic [FW-1:0] alu_mask,
  input logic          rf_we,
  input logic [2:0]    cc_field,
  input logic          cc_rel,
  input logic [FW-1:0] work_flags,
  input logic [FW-1:0] rf_flags,
  input logic          cond_taken
);

  // R2
  load_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t4_load && !t3_wb) |=> work_flags == $past(rf_flags));

  // R3
  alu_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_we && !t4_load) |=> (work_flags & $past(alu_mask)) == ($past(alu_flags) & $past(alu_mask)));

  // R5
  rf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!t3_wb && !rf_we && !af_swap) |=> $stable(rf_flags));

  // R10
  swap_keeps_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (af_swap && !alu_we && !t4_load) |=> $stable(work_flags));

  // R8
  zero_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cc_rel && cc_field == 3'b001) |-> cond_taken == work_flags[6]);

endmodule

bind flag_cond_unit flag_cond_unit_chk #(.FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .t4_load(t4_load), .t3_wb(t3_wb),
  .af_swap(af_swap), .alu_we(alu_we), .alu_flags(alu_flags),
  .alu_mask(alu_mask), .rf_we(rf_we), .cc_field(cc_field), .cc_rel(cc_rel),
  .work_flags(work_flags), .rf_flags(rf_flags), .cond_taken(cond_taken)
);

// File: tb/flag_cond_unit_tb.sv
module flag_cond_unit_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic t4_load = 0, t3_wb = 0, instr_end = 0, instr_mod_flags = 0, af_swap = 0;
  logic alu_we = 0, rf_we = 0, cc_rel = 0;
  logic [7:0] alu_flags = 0, alu_mask = 0, rf_wdata = 0;
  logic [2:0] cc_field = 0;
  logic [7:0] work_flags, rf_flags;
  logic carry, cond_taken;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  flag_cond_unit u_dut (
    .clk(clk), .rst_n(rst_n), .t4_load(t4_load), .t3_wb(t3_wb),
    .instr_end(instr_end), .instr_mod_flags(instr_mod_flags), .af_swap(af_swap),
    .alu_we(alu_we), .alu_flags(alu_flags), .alu_mask(alu_mask),
    .rf_we(rf_we), .rf_wdata(rf_wdata), .cc_field(cc_field), .cc_rel(cc_rel),
    .work_flags(work_flags), .rf_flags(rf_flags), .carry(carry), .cond_taken(cond_taken)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    t4_load = 0; t3_wb = 0; instr_end = 0; instr_mod_flags = 0;
    af_swap = 0; alu_we = 0; rf_we = 0;
  endtask

  task automatic rfw(input logic [7:0] v);
    rf_we = 1; rf_wdata = v; tick();
  endtask

  task automatic load();
    t4_load = 1; tick();
  endtask

  function automatic logic exp_cond(input logic [7:0] v, input logic [2:0] f, input logic rel);
    int sel, pos;
    sel = rel ? int'(f[1]) : int'(f[2:1]);
    pos = (sel == 0) ? 6 : (sel == 1) ? 0 : (sel == 2) ? 2 : 7;
    return v[pos] == f[0];
  endfunction

  initial begin
    #100000;
    nfail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1;
    // R1 reset state
    chk("R1 latch", work_flags, 0);
    chk("R1 rf", rf_flags, 0);
    af_swap = 1; tick();
    chk("R1 other bank", rf_flags, 0);
    af_swap = 1; tick();

    // R2 R8 R9 R13 sweep over every flag byte
    for (int v = 0; v < 256; v++) begin
      rfw(8'(v));
      chk("R11 direct write", rf_flags, v);
      load();
      chk("R2 load", work_flags, v);
      chk("R13 carry", carry, v & 1);
      for (int r = 0; r < 2; r++) begin
        for (int f = 0; f < 8; f++) begin
          cc_field = 3'(f); cc_rel = r[0]; #1;
          chk(r ? "R9 rel cond" : "R8 cond", cond_taken, exp_cond(8'(v), 3'(f), r[0]));
        end
      end
    end
    cc_rel = 0; cc_field = 0;

    // R3 ALU merge
    rfw(8'h00); load();
    alu_we = 1; alu_flags = 8'hFF; alu_mask = 8'h0F; tick();
    chk("R3 merge", work_flags, 8'h0F);
    chk("R3 rf untouched", rf_flags, 8'h00);
    alu_we = 1; alu_flags = 8'h00; alu_mask = 8'h81; tick();
    chk("R3 merge2", work_flags, 8'h0E);

    // R4 R6 write-back
    instr_end = 1; instr_mod_flags = 1; tick();
    chk("R4 no early wb", rf_flags, 8'h00);
    t3_wb = 1; tick();
    chk("R4 wb", rf_flags, 8'h0E);
    alu_we = 1; alu_flags = 8'hFF; alu_mask = 8'hFF; tick();
    t3_wb = 1; tick();
    chk("R6 no second wb", rf_flags, 8'h0E);

    // R5 no write-back when flags not modified
    instr_end = 1; instr_mod_flags = 0; tick();
    t3_wb = 1; tick();
    chk("R5 no wb", rf_flags, 8'h0E);

    // R12 ALU ignored during load
    rfw(8'h5A);
    t4_load = 1; alu_we = 1; alu_flags = 8'hFF; alu_mask = 8'hFF; tick();
    chk("R12 load wins", work_flags, 8'h5A);

    // R7 write-back before load in same cycle
    alu_we = 1; alu_flags = 8'hC3; alu_mask = 8'hFF; tick();
    instr_end = 1; instr_mod_flags = 1; tick();
    t3_wb = 1; t4_load = 1; tick();
    chk("R7 load sees wb", work_flags, 8'hC3);
    chk("R7 rf", rf_flags, 8'hC3);

    // R10 swap
    af_swap = 1; tick();
    chk("R10 other bank", rf_flags, 8'h00);
    chk("R10 latch kept", work_flags, 8'hC3);
    rfw(8'hA5);
    load();
    chk("R10 load new bank", work_flags, 8'hA5);
    af_swap = 1; tick();
    chk("R10 back", rf_flags, 8'hC3);

    // R4 target is the bank loaded from
    load();
    alu_we = 1; alu_flags = 8'h11; alu_mask = 8'hFF; tick();
    instr_end = 1; instr_mod_flags = 1; tick();
    af_swap = 1; tick();
    t3_wb = 1; tick();
    chk("R4 other bank untouched", rf_flags, 8'hA5);
    af_swap = 1; tick();
    chk("R4 source bank written", rf_flags, 8'h11);

    // R11 write-back beats direct write
    alu_we = 1; alu_flags = 8'h77; alu_mask = 8'hFF; tick();
    instr_end = 1; instr_mod_flags = 1; tick();
    t3_wb = 1; rf_we = 1; rf_wdata = 8'h99; tick();
    chk("R11 wb wins", rf_flags, 8'h77);

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule